// File: doc/BRIEF.md
# Virtual Cache Flush Sequencer

This block carries out cache flush commands for a direct-mapped, virtually indexed cache. A command is a 4-bit alternate-space code and a 30-bit word address. The sequencer walks the tag array through a read port and a write port. For each line it visits, it reads the stored tag and decides whether to clear that tag's valid bit. The decision depends on the flush kind, the stored context, the supervisor flag and the stored tag identifier.

There are three match rules: segment, page and context. Each rule can run on the single line that the address selects. It can also run as a sweep over a 4 KB window, visiting one line per line-size step. A further sweep clears every line of the window with no compare.

Each command is accepted through a ready/valid handshake. The block holds `busy` for the whole operation and pulses `done` in the cycle of the last line's write-back. Cache data storage, refill and address translation live elsewhere.

Top module: `vcf_flush_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, the block is idle: `cmd_ready`=1, `busy`=0, `done`=0, `tag_rd_en`=0, `tag_wr_en`=0.
- R2: A command is taken only on a clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low for every cycle the block is busy. A command held at the port while busy is accepted in the first idle cycle and is carried out in full, not dropped.
- R3: A visited line's index is the word address shifted right by LINE_SHIFT = log2(LINE_BYTES/4) and truncated to IDX_W bits. Every tag write goes to the line read in the previous cycle. A tag write keeps every bit of the read tag except bit 19 (valid), which it clears.
- R4: Codes 12, 13 and 14 visit one line. The tag read occurs in the cycle after acceptance, and the write-back (if any) and the one-cycle `done` pulse occur in the cycle after that.
- R5: Page rule (codes 6, 13): clear when tag bit 19 is 1, the context field matches, and tag[15:2] equals address bits [27:14].
- R6: Context rule (codes 7, 14): clear when tag bit 19 is 1, the context field matches, tag bit 20 (supervisor) is 0, and tag[13:2] equals address bits [25:14]. Tag bits [15:14] are not compared.
- R7: Segment rule (codes 5, 12): clear when tag bit 19 is 1, the context field matches, and tag[15:4] equals address bits [27:16]. Tag bits [3:2] are not compared.
- R8: Codes 5, 6 and 7 sweep 1024 >> LINE_SHIFT lines. Iteration i uses the address base OR (i << LINE_SHIFT), for i ascending from 0, at two cycles per line. `done` is therefore visible 2·(1024 >> LINE_SHIFT) cycles after acceptance.
- R9: Code 15 sweeps the same window as R8 and writes every visited line with bit 19 cleared, whatever the tag holds. Lines outside the window are untouched.
- R10: Any other code is accepted and completes with `done` two cycles after acceptance. It causes no tag write.
- R11: The context field is tag bits [22 +: CTX_W]. It is compared with `cur_ctx` as captured at acceptance, so later changes of `cur_ctx` have no effect on that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_code | input | 4 | Alternate-space flush code |
| cmd_addr | input | ADDR_W (30) | Word address of the line or window base |
| cur_ctx | input | CTX_W (3) | Current context number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the final line's write-back |
| tag_rd_en | output | 1 | Tag read request |
| tag_rd_idx | output | IDX_W (11) | Line index read |
| tag_rd_data | input | TAG_W (32) | Tag returned one cycle after the request |
| tag_wr_en | output | 1 | Tag write strobe |
| tag_wr_idx | output | IDX_W (11) | Line index written |
| tag_wr_data | output | TAG_W (32) | Tag value written |

## Verification
Two functions can fall in the same cycle:
- the final write-back and `done` of a 128-line sweep;
- the acceptance test of a new command that has been held at the port throughout the sweep.

The bench provokes this by presenting a single-line page flush directly after a sweep has been accepted. It judges the case in two ways. First, the stall must last exactly the sweep length plus nothing. Second, the held command's own tag write must arrive in order after every sweep write, with the value the reference predicts from the tags the sweep left behind.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

  localparam int CODE_W    = 4;
  localparam int VALID_POS = 19;
  localparam int SUPER_POS = 20;
  localparam int CTX_POS   = 22;

  localparam logic [CODE_W-1:0] CODE_SWEEP_SEG  = 4'd5;
  localparam logic [CODE_W-1:0] CODE_SWEEP_PAGE = 4'd6;
  localparam logic [CODE_W-1:0] CODE_SWEEP_CTX  = 4'd7;
  localparam logic [CODE_W-1:0] CODE_LINE_SEG   = 4'd12;
  localparam logic [CODE_W-1:0] CODE_LINE_PAGE  = 4'd13;
  localparam logic [CODE_W-1:0] CODE_LINE_CTX   = 4'd14;
  localparam logic [CODE_W-1:0] CODE_SWEEP_ALL  = 4'd15;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_SEG,
    FK_PAGE,
    FK_CTX,
    FK_ALL
  } fkind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } seq_state_e;

endpackage

// File: rtl/vcf_cmd_decode.sv
module vcf_cmd_decode
  import vcf_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output fkind_e            kind,
  output logic              sweep
);

  always_comb begin
    kind  = FK_NONE;
    sweep = 1'b0;
    unique case (code)
      CODE_SWEEP_SEG:  begin kind = FK_SEG;  sweep = 1'b1; end
      CODE_SWEEP_PAGE: begin kind = FK_PAGE; sweep = 1'b1; end
      CODE_SWEEP_CTX:  begin kind = FK_CTX;  sweep = 1'b1; end
      CODE_LINE_SEG:   kind = FK_SEG;
      CODE_LINE_PAGE:  kind = FK_PAGE;
      CODE_LINE_CTX:   kind = FK_CTX;
      CODE_SWEEP_ALL:  begin kind = FK_ALL;  sweep = 1'b1; end
      default:         kind = FK_NONE;
    endcase
  end

endmodule

// File: rtl/vcf_line_walker.sv
module vcf_line_walker #(
  parameter int ADDR_W     = 30,
  parameter int LINE_SHIFT = 3,
  parameter int ITER_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sweep_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              step,
  output logic [ADDR_W-1:0] va,
  output logic              last
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic              sweep_q, sweep_d;
  logic              walk_en;

  assign walk_en = load | step;

  always_comb begin
    base_d  = base_q;
    sweep_d = sweep_q;
    iter_d  = iter_q;
    if (load) begin
      base_d  = base_in;
      sweep_d = sweep_in;
      iter_d  = '0;
    end else if (step) begin
      iter_d  = iter_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      sweep_q <= 1'b0;
      iter_q  <= '0;
    end else if (walk_en) begin
      base_q  <= base_d;
      sweep_q <= sweep_d;
      iter_q  <= iter_d;
    end
  end

  // Sweep addresses are formed by OR, so base bits inside the window persist.
  assign va   = sweep_q ? (base_q | (ADDR_W'(iter_q) << LINE_SHIFT)) : base_q;
  assign last = !sweep_q || (&iter_q);

endmodule

// File: rtl/vcf_line_match.sv
module vcf_line_match
  import vcf_pkg::*;
#(
  parameter int CTX_W = 3
) (
  input  fkind_e           kind,
  input  logic             t_valid,
  input  logic             t_super,
  input  logic [CTX_W-1:0] t_ctx,
  input  logic [13:0]      t_id,
  input  logic [CTX_W-1:0] ctx,
  input  logic [13:0]      va_id,
  output logic             hit
);

  logic ctx_same;
  logic page_id_ok;
  logic seg_id_ok;
  logic ctx_id_ok;

  assign ctx_same   = (t_ctx == ctx);
  assign page_id_ok = (t_id == va_id);
  assign seg_id_ok  = (t_id[13:2] == va_id[13:2]);
  assign ctx_id_ok  = (t_id[11:0] == va_id[11:0]);

  always_comb begin
    unique case (kind)
      FK_SEG:  hit = t_valid && ctx_same && seg_id_ok;
      FK_PAGE: hit = t_valid && ctx_same && page_id_ok;
      FK_CTX:  hit = t_valid && ctx_same && !t_super && ctx_id_ok;
      FK_ALL:  hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcf_flush_seq.sv
module vcf_flush_seq
  import vcf_pkg::*;
#(
  parameter int LINE_BYTES    = 32,
  parameter int ADDR_W        = 30,
  parameter int TAG_W         = 32,
  parameter int CTX_W         = 3,
  parameter int CACHE_WORD_W  = 14,
  parameter int WINDOW_WORD_W = 10,
  localparam int LINE_SHIFT   = $clog2(LINE_BYTES / 4),
  localparam int IDX_W        = CACHE_WORD_W - LINE_SHIFT,
  localparam int ITER_W       = WINDOW_WORD_W - LINE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CTX_W-1:0]  cur_ctx,
  output logic              busy,
  output logic              done,
  output logic              tag_rd_en,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic [TAG_W-1:0]  tag_rd_data,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic [TAG_W-1:0]  tag_wr_data
);

  localparam logic [TAG_W-1:0] VALID_MASK = TAG_W'(1) << VALID_POS;

  seq_state_e        state_q, state_d;
  fkind_e            kind_q, kind_d, dec_kind;
  logic [CTX_W-1:0]  ctx_q, ctx_d;
  logic              dec_sweep;
  logic              accept;
  logic              step;
  logic              last;
  logic              hit;
  logic [ADDR_W-1:0] va;
  logic              unused_va_bits;

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign step   = (state_q == ST_WRITE) && !last;

  vcf_cmd_decode u_dec (
    .code  (cmd_code),
    .kind  (dec_kind),
    .sweep (dec_sweep)
  );

  vcf_line_walker #(
    .ADDR_W     (ADDR_W),
    .LINE_SHIFT (LINE_SHIFT),
    .ITER_W     (ITER_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .sweep_in (dec_sweep),
    .base_in  (cmd_addr),
    .step     (step),
    .va       (va),
    .last     (last)
  );

  vcf_line_match #(
    .CTX_W (CTX_W)
  ) u_match (
    .kind    (kind_q),
    .t_valid (tag_rd_data[VALID_POS]),
    .t_super (tag_rd_data[SUPER_POS]),
    .t_ctx   (tag_rd_data[CTX_POS +: CTX_W]),
    .t_id    (tag_rd_data[15:2]),
    .ctx     (ctx_q),
    .va_id   (va[27:14]),
    .hit     (hit)
  );

  assign unused_va_bits = ^{va[ADDR_W-1:28], va[LINE_SHIFT-1:0]};

  // Next state
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    ctx_d   = ctx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_READ;
          kind_d  = dec_kind;
          ctx_d   = cur_ctx;
        end
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= FK_NONE;
      ctx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q <= kind_d;
        ctx_q  <= ctx_d;
      end
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign busy        = (state_q != ST_IDLE);
  assign tag_rd_en   = (state_q == ST_READ);
  assign tag_rd_idx  = va[LINE_SHIFT +: IDX_W];
  assign tag_wr_en   = (state_q == ST_WRITE) && hit;
  assign tag_wr_idx  = va[LINE_SHIFT +: IDX_W];
  assign tag_wr_data = tag_rd_data & ~VALID_MASK;
  assign done        = (state_q == ST_WRITE) && last;

endmodule

// File: rtl/vcf_flush_seq_chk.sv
module vcf_flush_seq_chk
  import vcf_pkg::*;
#(
  parameter int TAG_W = 32,
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             busy,
  input logic             done,
  input logic             tag_rd_en,
  input logic [IDX_W-1:0] tag_rd_idx,
  input logic [TAG_W-1:0] tag_rd_data,
  input logic             tag_wr_en,
  input logic [IDX_W-1:0] tag_wr_idx,
  input logic [TAG_W-1:0] tag_wr_data
);

  localparam logic [TAG_W-1:0] VM = TAG_W'(1) << VALID_POS;

  // R3
  wr_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> !tag_wr_data[VALID_POS]);

  // R3
  wr_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> ((tag_wr_data | VM) == (tag_rd_data | VM)));

  // R3
  wr_same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> ($past(tag_rd_en) && (tag_wr_idx == $past(tag_rd_idx))));

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && tag_rd_en && !cmd_ready));

  // R8
  read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_en |=> (!tag_rd_en && busy));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && cmd_ready));

  // R1
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_wr_en || done) |-> busy);

endmodule

bind vcf_flush_seq vcf_flush_seq_chk #(
  .TAG_W (TAG_W),
  .IDX_W (IDX_W)
) u_chk (.*);

// File: tb/vcf_flush_seq_tb.sv
module vcf_flush_seq_tb_top;

  localparam int LS    = 3;
  localparam int IDXW  = 11;
  localparam int NLINE = 1024 >> LS;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [3:0]  cmd_code;
  logic [29:0] cmd_addr;
  logic [2:0]  cur_ctx;
  logic        busy;
  logic        done;
  logic        tag_rd_en;
  logic [IDXW-1:0] tag_rd_idx;
  logic [31:0] tag_rd_data;
  logic        tag_wr_en;
  logic [IDXW-1:0] tag_wr_idx;
  logic [31:0] tag_wr_data;

  logic [31:0] mem   [0:(1<<IDXW)-1];
  logic [31:0] model [0:(1<<IDXW)-1];
  logic        pl_en;
  logic [IDXW-1:0] pl_idx;
  logic [31:0] pl_data;

  logic [IDXW-1:0] eidx_q[$];
  logic [31:0]     edat_q[$];
  string           ereq_q[$];

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int issued = 0;
  bit finished = 0;

  vcf_flush_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cur_ctx(cur_ctx),
    .busy(busy), .done(done), .tag_rd_en(tag_rd_en), .tag_rd_idx(tag_rd_idx),
    .tag_rd_data(tag_rd_data), .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx),
    .tag_wr_data(tag_wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Tag array with one-cycle read latency
  always @(posedge clk) begin
    if (tag_rd_en) tag_rd_data <= mem[tag_rd_idx];
    if (tag_wr_en) mem[tag_wr_idx] <= tag_wr_data;
    else if (pl_en) mem[pl_idx] <= pl_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) done_seen++;
      if (tag_wr_en) begin
        if (eidx_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected tag write", {21'd0, tag_wr_idx}, 32'd0);
        end else begin
          logic [IDXW-1:0] ei;
          logic [31:0] ed;
          string er;
          ei = eidx_q.pop_front();
          ed = edat_q.pop_front();
          er = ereq_q.pop_front();
          chk(tag_wr_idx == ei, er, "write index", {21'd0, tag_wr_idx}, {21'd0, ei});
          chk(tag_wr_data == ed, er, "write data", tag_wr_data, ed);
        end
      end
    end
  end

  function automatic logic [31:0] mk(input bit v, input bit s, input bit w,
                                     input logic [2:0] c, input logic [13:0] id);
    logic [31:0] t;
    t = 32'd0;
    t[19] = v; t[20] = s; t[21] = w; t[24:22] = c; t[15:2] = id;
    return t;
  endfunction

  function automatic bit ref_hit(input logic [3:0] code, input logic [31:0] t,
                                 input logic [29:0] va, input logic [2:0] c);
    bit v, cm;
    v  = t[19];
    cm = (t[24:22] == c);
    case (code)
      4'd5, 4'd12: return v && cm && (t[15:4] == va[27:16]);
      4'd6, 4'd13: return v && cm && (t[15:2] == va[27:14]);
      4'd7, 4'd14: return v && cm && !t[20] && (t[13:2] == va[25:14]);
      4'd15:       return 1'b1;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic bit is_sweep(input logic [3:0] code);
    return (code == 4'd5) || (code == 4'd6) || (code == 4'd7) || (code == 4'd15);
  endfunction

  function automatic logic [29:0] line_va(input logic [29:0] base, input int i);
    return base | (30'(i) << LS);
  endfunction

  function automatic logic [IDXW-1:0] idx_of(input logic [29:0] va);
    return va[LS +: IDXW];
  endfunction

  function automatic logic [31:0] pat(input int i, input logic [29:0] va);
    logic [13:0] id;
    logic [31:0] t;
    id = va[27:14];
    if (i % 3 == 0) id = id ^ 14'h0100;
    if (i % 4 == 1) id = id ^ 14'h0001;
    if (i % 6 == 2) id = id ^ 14'h2000;
    t = mk(i % 4 != 3, i % 5 == 0, i[0], (i % 7 == 0) ? 3'd1 : 3'd5, id);
    return t | 32'h0003_0001;
  endfunction

  task automatic pl(input logic [IDXW-1:0] i, input logic [31:0] d);
    pl_en = 1'b1; pl_idx = i; pl_data = d;
    model[i] = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic pl_window(input logic [29:0] base);
    for (int i = 0; i < NLINE; i++) pl(idx_of(line_va(base, i)), pat(i, line_va(base, i)));
  endtask

  // Driver: predicts writes, then presents the command (caller is at a negedge)
  task automatic issue(input logic [3:0] code, input logic [29:0] addr,
                       input string req, output int stalls);
    int n;
    n = is_sweep(code) ? NLINE : 1;
    for (int i = 0; i < n; i++) begin
      logic [29:0] va;
      logic [IDXW-1:0] ix;
      va = is_sweep(code) ? line_va(addr, i) : addr;
      ix = idx_of(va);
      if (ref_hit(code, model[ix], va, cur_ctx)) begin
        model[ix] = model[ix] & ~32'h0008_0000;
        eidx_q.push_back(ix);
        edat_q.push_back(model[ix]);
        ereq_q.push_back(req);
      end
    end
    issued++;
    stalls = 0;
    cmd_valid = 1'b1; cmd_code = code; cmd_addr = addr;
    while (!cmd_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int exp, input string req);
    int n;
    n = 1;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (exp > 0) chk(n == exp, req, "done latency", n, exp);
    @(negedge clk);
  endtask

  task automatic check_line(input logic [IDXW-1:0] ix, input string req, input string what);
    chk(mem[ix] === model[ix], req, what, mem[ix], model[ix]);
  endtask

  task automatic check_window(input logic [29:0] base, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < NLINE; i++)
      if (mem[idx_of(line_va(base, i))] !== model[idx_of(line_va(base, i))]) bad++;
    chk(bad == 0, req, "window lines differing", bad, 0);
  endtask

  initial begin
    int st;
    logic [29:0] va1, va2, va3, bp, bs, bc, bu;
    logic [IDXW-1:0] i1, i2, i3, io;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 4'd0; cmd_addr = '0; cur_ctx = 3'd5;
    pl_en = 1'b0; pl_idx = '0; pl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !busy && !done && !tag_rd_en && !tag_wr_en, "R1", "idle after reset",
        {27'd0, cmd_ready, busy, done, tag_rd_en, tag_wr_en}, 32'h10);

    va1 = 30'h0ABC_D5A8; i1 = idx_of(va1);
    va2 = 30'h0123_4560; i2 = idx_of(va2);
    va3 = 30'h02F0_ABC8; i3 = idx_of(va3);

    // R5 page hit, R11 context captured at acceptance, R4 latency
    pl(i1, mk(1, 0, 1, 3'd5, va1[27:14]) | 32'h0001_0003);
    issue(4'd13, va1, "R5", st);
    cur_ctx = 3'd2;
    wait_done(2, "R4");
    cur_ctx = 3'd5;
    chk(mem[i1][19] == 1'b0, "R11", "valid cleared with captured context", {31'd0, mem[i1][19]}, 0);
    check_line(i1, "R5", "page hit line");
    // R5 page identifier mismatch in bit 0
    pl(i1, mk(1, 0, 1, 3'd5, va1[27:14] ^ 14'h0001));
    issue(4'd13, va1, "R5", st); wait_done(2, "R4");
    chk(mem[i1][19] == 1'b1, "R5", "id mismatch keeps valid", {31'd0, mem[i1][19]}, 1);
    // R11 context mismatch
    pl(i1, mk(1, 0, 1, 3'd2, va1[27:14]));
    issue(4'd13, va1, "R11", st); wait_done(2, "R4");
    chk(mem[i1][19] == 1'b1, "R11", "context mismatch keeps valid", {31'd0, mem[i1][19]}, 1);

    // R6 context rule: supervisor line kept, user line cleared, top id bits ignored
    pl(i2, mk(1, 1, 0, 3'd5, {~va2[27:26], va2[25:14]}));
    issue(4'd14, va2, "R6", st); wait_done(2, "R4");
    chk(mem[i2][19] == 1'b1, "R6", "supervisor line kept", {31'd0, mem[i2][19]}, 1);
    pl(i2, mk(1, 0, 0, 3'd5, {~va2[27:26], va2[25:14]}));
    issue(4'd14, va2, "R6", st); wait_done(2, "R4");
    chk(mem[i2][19] == 1'b0, "R6", "user line cleared", {31'd0, mem[i2][19]}, 0);

    // R7 segment rule: low id bits ignored, segment bits compared
    pl(i3, mk(1, 0, 1, 3'd5, {va3[27:16], ~va3[15:14]}));
    issue(4'd12, va3, "R7", st); wait_done(2, "R4");
    chk(mem[i3][19] == 1'b0, "R7", "segment hit cleared", {31'd0, mem[i3][19]}, 0);
    pl(i3, mk(1, 0, 1, 3'd5, {va3[27:16] ^ 12'h001, va3[15:14]}));
    issue(4'd12, va3, "R7", st); wait_done(2, "R4");
    chk(mem[i3][19] == 1'b1, "R7", "segment mismatch kept", {31'd0, mem[i3][19]}, 1);

    // R10 unknown codes
    pl(i1, mk(1, 0, 1, 3'd5, va1[27:14]));
    issue(4'd2, va1, "R10", st); wait_done(2, "R10");
    issue(4'd9, va1, "R10", st); wait_done(2, "R10");
    chk(mem[i1][19] == 1'b1, "R10", "unknown code leaves line", {31'd0, mem[i1][19]}, 1);

    // R8 sweeps of each kind
    bp = 30'h0155_0000; bs = 30'h0266_0400; bc = 30'h0377_0800;
    pl_window(bp); issue(4'd6, bp, "R8", st); wait_done(2 * NLINE, "R8"); check_window(bp, "R5");
    pl_window(bs); issue(4'd5, bs, "R8", st); wait_done(2 * NLINE, "R8"); check_window(bs, "R7");
    pl_window(bc); issue(4'd7, bc, "R8", st); wait_done(2 * NLINE, "R8"); check_window(bc, "R6");

    // R9 unconditional sweep with OR-colliding base and an outside line
    bu = 30'h0044_0048;
    io = idx_of(bu) ^ 11'h080;
    pl_window(bu);
    pl(io, mk(1, 0, 1, 3'd5, 14'h0));
    issue(4'd15, bu, "R9", st); wait_done(2 * NLINE, "R9");
    check_window(bu, "R9");
    chk(mem[io][19] == 1'b1, "R9", "outside line untouched", {31'd0, mem[io][19]}, 1);

    // R2 command held while a sweep runs
    pl_window(bp);
    pl(i1, mk(1, 0, 1, 3'd5, va1[27:14]));
    issue(4'd6, bp, "R2", st);
    chk(busy && !cmd_ready, "R2", "not ready while busy", {30'd0, busy, cmd_ready}, 32'h2);
    issue(4'd13, va1, "R2", st);
    chk(st == 2 * NLINE, "R2", "stall cycles", st, 2 * NLINE);
    wait_done(2, "R2");
    check_window(bp, "R2");
    chk(mem[i1][19] == 1'b0, "R2", "held command carried out", {31'd0, mem[i1][19]}, 0);

    repeat (3) @(negedge clk);
    chk(eidx_q.size() == 0, "R3", "expected writes left over", eidx_q.size(), 0);
    chk(done_seen == issued, "R4", "done pulses", done_seen, issued);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule